// File: doc/BRIEF.md
# Timer capture/compare channel register

This block is one channel of a 16-bit timer. It holds a 16-bit value that a processor reaches over an 8-bit register bus as an upper byte and a lower byte. The channel works in one of two modes, picked by a two-bit mode field. In capture mode, a strobe from the pin edge logic copies the free-running counter into the register. In compare mode, the register holds a target value. When the counter reaches that target, the block emits a one-cycle compare pulse.

Both modes set a sticky channel flag, which a separate strobe clears. The register is read and written one byte at a time, so an interlock keeps the 16-bit value coherent:
- Reading the upper byte freezes capture until the lower byte has been read.
- Writing the upper byte holds off compare matches until the lower byte has been written.

Pin edge detection, prescaling and output waveform generation sit in neighbouring blocks.

Top module: `tmr_chan_reg`

## Requirements
- R1: `byte_hi`=1 selects bits 15..8 and `byte_hi`=0 selects bits 7..0 of the register. A read (`bus_rd`) returns the selected byte of the register as it stood in the read cycle. That byte appears on `bus_rdata` in the next cycle and holds until the next read. `bus_rd` and `bus_wr` are never asserted together.
- R2: `mode_sel` = 2'b00 selects capture mode, and every other value (01, 10, 11) selects compare mode. In compare mode `cap_stb` has no effect on the register or on the flag.
- R3: In capture mode, a `cap_stb` that is not blocked loads the `cnt_val` of that same cycle into all 16 bits. If a bus write falls in the same cycle, the capture wins.
- R4: In capture mode, an upper-byte read blocks captures in its own cycle and in every cycle up to and including the next lower-byte read. A blocked capture is discarded: the register keeps its value and the flag is not set.
- R5: In compare mode, with compare enabled, a cycle in which `cnt_val` equals the full 16-bit register makes `cmp_pulse` high for exactly the following cycle. Each matching cycle produces its own pulse.
- R6: In compare mode, an upper-byte write suppresses matches in its own cycle and in every cycle up to and including the next lower-byte write. From the following cycle on, the new 16-bit value is compared.
- R7: `chan_flag` goes high in the cycle after an accepted capture or a match, and stays high until `flag_clr`. If a set and a clear fall in the same cycle, the set wins.
- R8: A cycle in which `mode_sel` differs from its value in the previous cycle releases both interlocks at the end of that cycle. No access in that cycle leaves a lock behind.
- R9: Bus writes update the addressed byte in either mode. A write in capture mode neither creates nor releases the capture lock. A read in compare mode neither creates nor releases the compare lock.
- R10: After a synchronous reset, `chan_flag`, `cmp_pulse` and `bus_rdata` are 0 and both interlocks are released. The register contents stay undefined until the first capture or write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_val | input | 16 | Free-running counter value |
| cap_stb | input | 1 | Capture event strobe from the pin edge logic |
| mode_sel | input | 2 | Channel mode; 00 = capture, else compare |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| byte_hi | input | 1 | Byte select: 1 = bits 15..8, 0 = bits 7..0 |
| bus_wdata | input | 8 | Write data byte |
| flag_clr | input | 1 | Clears the channel flag |
| bus_rdata | output | 8 | Read data byte, registered |
| chan_flag | output | 1 | Sticky channel event flag |
| cmp_pulse | output | 1 | One-cycle compare match pulse |

## Verification
The sharpest collision is a capture strobe in the same cycle as an upper-byte read. The read must return the old upper byte and the strobe must be dropped, so the later lower-byte read still pairs with it. A second collision is an upper-byte write while the counter equals the old target, which must produce no pulse.

The bench provokes both by driving the strobe and the bus access in one cycle, with counter values that differ in both bytes. A behavioural model then predicts the read data, flag and pulse, and every cycle is compared against it. A flag clear coinciding with a capture, and a mode change while a lock is held, are provoked the same way.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;

  localparam logic [1:0] MODE_CAPTURE = 2'b00;

  typedef struct packed {
    logic hi_rd;
    logic lo_rd;
    logic hi_wr;
    logic lo_wr;
  } bus_acc_t;

  function automatic logic is_capture(input logic [1:0] mode);
    return mode == MODE_CAPTURE;
  endfunction

endpackage

// File: rtl/chan_lock_ctl.sv
module chan_lock_ctl
  import tmr_chan_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode_sel,
  input  bus_acc_t   acc,
  output logic       cap_block,
  output logic       cmp_en
);

  logic [1:0] mode_q;
  logic       cap_lock;
  logic       cmp_lock;
  logic       mode_chg;
  logic       cap_mode;

  assign cap_mode = is_capture(mode_sel);
  assign mode_chg = mode_sel != mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= MODE_CAPTURE;
      cap_lock <= 1'b0;
      cmp_lock <= 1'b0;
    end else begin
      mode_q <= mode_sel;
      if (mode_chg) begin
        cap_lock <= 1'b0;
        cmp_lock <= 1'b0;
      end else begin
        if (cap_mode && acc.hi_rd)       cap_lock <= 1'b1;
        else if (acc.lo_rd)              cap_lock <= 1'b0;
        if (!cap_mode && acc.hi_wr)      cmp_lock <= 1'b1;
        else if (acc.lo_wr)              cmp_lock <= 1'b0;
      end
    end
  end

  // an upper read blocks in its own cycle as well as while latched
  assign cap_block = cap_lock | (cap_mode & acc.hi_rd);
  assign cmp_en    = ~cap_mode & ~cmp_lock & ~acc.hi_wr;

  AST_LOCKS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(cap_lock && cmp_lock)); // R8
  AST_CAPLOCK_IN_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    cap_lock |-> (mode_q == MODE_CAPTURE)); // R4
  AST_MODE_CHG_UNLOCKS: assert property (@(posedge clk) disable iff (rst)
    mode_chg |=> (!cap_lock && !cmp_lock)); // R8
  AST_LO_READ_RELEASES: assert property (@(posedge clk) disable iff (rst)
    acc.lo_rd |=> !cap_lock); // R4
  AST_CMPLOCK_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (cmp_lock && !acc.lo_wr && !mode_chg) |=> cmp_lock); // R6

endmodule

// File: rtl/chan_store.sv
module chan_store #(
  parameter int BUS_W = 8,
  parameter int CNT_W = 2 * BUS_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             cap_take,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic             byte_hi,
  input  logic [BUS_W-1:0] wdata,
  output logic [BUS_W-1:0] rdata,
  output logic [CNT_W-1:0] reg_val
);

  localparam int NLANE = CNT_W / BUS_W;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    localparam logic IS_TOP = (g == NLANE - 1);
    logic [BUS_W-1:0] lane_q;

    // value storage carries no reset: contents are undefined until loaded
    always_ff @(posedge clk) begin
      if (cap_take)
        lane_q <= cnt_val[g*BUS_W +: BUS_W];
      else if (wr_en && (byte_hi == IS_TOP))
        lane_q <= wdata;
    end

    assign reg_val[g*BUS_W +: BUS_W] = lane_q;
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else if (rd_en)
      rdata <= byte_hi ? reg_val[CNT_W-1 -: BUS_W] : reg_val[BUS_W-1:0];
  end

  AST_CAPTURE_LOAD: assert property (@(posedge clk) disable iff (rst)
    cap_take |=> (reg_val == $past(cnt_val))); // R3
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata)); // R1
  AST_READ_LOW_BYTE: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !byte_hi) |=> (rdata == $past(reg_val[BUS_W-1:0]))); // R1

endmodule

// File: rtl/chan_event.sv
module chan_event #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic [CNT_W-1:0] reg_val,
  input  logic             cmp_en,
  input  logic             cap_take,
  input  logic             flag_clr,
  output logic             chan_flag,
  output logic             cmp_pulse
);

  logic match;

  assign match = cmp_en && (cnt_val == reg_val);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_pulse <= 1'b0;
      chan_flag <= 1'b0;
    end else begin
      cmp_pulse <= match;
      if (cap_take || match)
        chan_flag <= 1'b1;
      else if (flag_clr)
        chan_flag <= 1'b0;
    end
  end

  AST_PULSE_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
    cmp_pulse |-> chan_flag); // R7
  AST_NO_PULSE_DISABLED: assert property (@(posedge clk) disable iff (rst)
    !cmp_en |=> !cmp_pulse); // R6
  AST_CAPTURE_FLAGS: assert property (@(posedge clk) disable iff (rst)
    cap_take |=> chan_flag); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (chan_flag && !flag_clr) |=> chan_flag); // R7

endmodule

// File: rtl/tmr_chan_reg.sv
module tmr_chan_reg
  import tmr_chan_pkg::*;
#(
  parameter  int BUS_W = 8,
  localparam int CNT_W = 2 * BUS_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             cap_stb,
  input  logic [1:0]       mode_sel,
  input  logic             bus_rd,
  input  logic             bus_wr,
  input  logic             byte_hi,
  input  logic [BUS_W-1:0] bus_wdata,
  input  logic             flag_clr,
  output logic [BUS_W-1:0] bus_rdata,
  output logic             chan_flag,
  output logic             cmp_pulse
);

  bus_acc_t         acc;
  logic             cap_block;
  logic             cmp_en;
  logic             cap_take;
  logic [CNT_W-1:0] reg_val;

  always_comb begin
    acc.hi_rd = bus_rd &  byte_hi;
    acc.lo_rd = bus_rd & ~byte_hi;
    acc.hi_wr = bus_wr &  byte_hi;
    acc.lo_wr = bus_wr & ~byte_hi;
  end

  assign cap_take = is_capture(mode_sel) & cap_stb & ~cap_block;

  chan_lock_ctl u_lock (
    .clk       (clk),
    .rst       (rst),
    .mode_sel  (mode_sel),
    .acc       (acc),
    .cap_block (cap_block),
    .cmp_en    (cmp_en)
  );

  chan_store #(.BUS_W(BUS_W), .CNT_W(CNT_W)) u_store (
    .clk      (clk),
    .rst      (rst),
    .cnt_val  (cnt_val),
    .cap_take (cap_take),
    .wr_en    (bus_wr),
    .rd_en    (bus_rd),
    .byte_hi  (byte_hi),
    .wdata    (bus_wdata),
    .rdata    (bus_rdata),
    .reg_val  (reg_val)
  );

  chan_event #(.CNT_W(CNT_W)) u_evt (
    .clk       (clk),
    .rst       (rst),
    .cnt_val   (cnt_val),
    .reg_val   (reg_val),
    .cmp_en    (cmp_en),
    .cap_take  (cap_take),
    .flag_clr  (flag_clr),
    .chan_flag (chan_flag),
    .cmp_pulse (cmp_pulse)
  );

  AST_BLOCKED_DISCARDED: assert property (@(posedge clk) disable iff (rst)
    (cap_stb && cap_block && !bus_wr) |=> $stable(reg_val)); // R4
  AST_COMPARE_NO_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (!is_capture(mode_sel) && !bus_wr) |=> $stable(reg_val)); // R2
  AST_CAPTURE_NO_PULSE: assert property (@(posedge clk) disable iff (rst)
    is_capture(mode_sel) |=> !cmp_pulse); // R2

endmodule

// File: tb/tmr_chan_reg_test.sv
`timescale 1ns/1ps
module tmr_chan_reg_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cnt_val = '0;
  logic        cap_stb = 1'b0;
  logic [1:0]  mode_sel = 2'b00;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic        byte_hi = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic        flag_clr = 1'b0;
  logic [7:0]  bus_rdata;
  logic        chan_flag;
  logic        cmp_pulse;

  int    total = 0;
  int    bad = 0;
  bit    done = 1'b0;
  string cur_req = "R10";

  always #2.5 clk = ~clk;

  tmr_chan_reg uut (
    .clk(clk), .rst(rst), .cnt_val(cnt_val), .cap_stb(cap_stb),
    .mode_sel(mode_sel), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .byte_hi(byte_hi), .bus_wdata(bus_wdata), .flag_clr(flag_clr),
    .bus_rdata(bus_rdata), .chan_flag(chan_flag), .cmp_pulse(cmp_pulse)
  );

  // behavioural reference model
  logic [15:0] m_reg;
  bit   [1:0]  m_known;
  bit          m_cap_lock, m_cmp_lock, m_flag, m_pulse, m_rd_known;
  logic [1:0]  m_mode_q;
  logic [7:0]  m_rdata;

  always @(posedge clk) begin : model
    bit capm, chg, blocked, take, en, match;
    if (rst) begin
      m_flag = 0; m_pulse = 0; m_rdata = 0; m_rd_known = 1;
      m_cap_lock = 0; m_cmp_lock = 0; m_mode_q = 2'b00;
    end else begin
      capm    = (mode_sel == 2'b00);
      chg     = (mode_sel != m_mode_q);
      blocked = m_cap_lock || (capm && bus_rd && byte_hi);
      take    = capm && cap_stb && !blocked;
      en      = !capm && !m_cmp_lock && !(bus_wr && byte_hi);
      match   = en && (m_known == 2'b11) && (cnt_val == m_reg);
      if (bus_rd) begin
        m_rdata    = byte_hi ? m_reg[15:8] : m_reg[7:0];
        m_rd_known = byte_hi ? m_known[1] : m_known[0];
      end
      if (take) begin
        m_reg = cnt_val; m_known = 2'b11;
      end else if (bus_wr) begin
        if (byte_hi) begin m_reg[15:8] = bus_wdata; m_known[1] = 1; end
        else         begin m_reg[7:0]  = bus_wdata; m_known[0] = 1; end
      end
      m_pulse = match;
      if (take || match) m_flag = 1;
      else if (flag_clr) m_flag = 0;
      if (chg) begin
        m_cap_lock = 0; m_cmp_lock = 0;
      end else begin
        if (capm && bus_rd && byte_hi) m_cap_lock = 1;
        else if (bus_rd && !byte_hi)   m_cap_lock = 0;
        if (!capm && bus_wr && byte_hi) m_cmp_lock = 1;
        else if (bus_wr && !byte_hi)    m_cmp_lock = 0;
      end
      m_mode_q = mode_sel;
    end
  end

  task automatic check(input string what, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    check("chan_flag", {15'd0, chan_flag}, {15'd0, m_flag});
    check("cmp_pulse", {15'd0, cmp_pulse}, {15'd0, m_pulse});
    if (m_rd_known) check("bus_rdata", {8'd0, bus_rdata}, {8'd0, m_rdata});
  endtask

  // drive one cycle (called just after a falling edge), then compare
  task automatic tick(input logic [15:0] c, input bit cs = 0, input bit rd = 0,
                      input bit wr = 0, input bit hi = 0,
                      input logic [7:0] wd = 8'h00, input bit clr = 0);
    cnt_val = c; cap_stb = cs; bus_rd = rd; bus_wr = wr;
    byte_hi = hi; bus_wdata = wd; flag_clr = clr;
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    cur_req = "R10 reset";
    compare_all();
    rst = 1'b0;
    tick(16'h0000);

    cur_req = "R3 capture";
    tick(16'h1234, 1);
    cur_req = "R1 byte read";
    tick(16'h1235, 0, 1, 0, 1);
    tick(16'h1236, 0, 1, 0, 0);
    cur_req = "R7 clear";
    tick(16'h1237, 0, 0, 0, 0, 8'h00, 1);
    tick(16'h1238);
    cur_req = "R7 set beats clear";
    tick(16'h2345, 1, 0, 0, 0, 8'h00, 1);
    tick(16'h2346, 0, 0, 0, 0, 8'h00, 1);
    tick(16'h2347);

    cur_req = "R4 capture lock";
    tick(16'hA5C3, 1);
    tick(16'hA5C4, 0, 0, 0, 0, 8'h00, 1);
    tick(16'h5A3C, 1, 1, 0, 1);
    for (int i = 0; i < 4; i++) tick(16'h7000 + 16'(i), 1);
    tick(16'h0F0F, 1, 1, 0, 0);
    tick(16'h0F10);
    tick(16'h6E6E, 1);
    tick(16'h6E6F, 0, 1, 0, 1);
    tick(16'h6E70, 0, 1, 0, 0);

    cur_req = "R3 capture beats write";
    tick(16'hBEEF, 1, 0, 1, 1, 8'h11);
    tick(16'hBEF0, 0, 1, 0, 1);
    cur_req = "R9 write in capture";
    tick(16'h0001, 0, 0, 1, 1, 8'h3C);
    tick(16'hC001, 1);
    tick(16'hC002, 0, 1, 0, 1);
    tick(16'hC003, 0, 0, 1, 0, 8'h99);
    tick(16'hD004, 1);
    tick(16'hD005, 0, 1, 0, 0);
    tick(16'hD006, 1);
    tick(16'hD007, 0, 1, 0, 1);
    tick(16'hD008, 0, 1, 0, 0);

    cur_req = "R2 strobe in compare";
    mode_sel = 2'b01;
    tick(16'h0000, 0, 0, 1, 1, 8'h00);
    tick(16'h0000, 0, 0, 1, 0, 8'h40);
    tick(16'h0000, 0, 0, 0, 0, 8'h00, 1);
    tick(16'h0041, 1);
    tick(16'h0042, 0, 1, 0, 0);
    cur_req = "R5 compare";
    for (int i = 0; i < 6; i++) tick(16'h003D + 16'(i));
    tick(16'h0040);
    tick(16'h0040);
    tick(16'h0041, 0, 0, 0, 0, 8'h00, 1);

    cur_req = "R6 compare lock";
    tick(16'h0040, 0, 0, 1, 1, 8'h01);
    tick(16'h0040);
    tick(16'h0140);
    tick(16'h0150, 0, 0, 1, 0, 8'h50);
    tick(16'h0150);
    tick(16'h0151, 0, 0, 0, 0, 8'h00, 1);

    cur_req = "R9 read in compare";
    tick(16'h0000, 0, 1, 0, 1);
    tick(16'h0150);
    tick(16'h0150, 0, 1, 0, 0);

    cur_req = "R2 mode 11 compares";
    mode_sel = 2'b11;
    tick(16'h0150);
    tick(16'h0151, 0, 0, 0, 0, 8'h00, 1);

    cur_req = "R8 mode change releases compare lock";
    tick(16'h0000, 0, 0, 1, 1, 8'h07);
    tick(16'h0750);
    mode_sel = 2'b10;
    tick(16'h0750);
    tick(16'h0750);
    tick(16'h0751, 0, 0, 0, 0, 8'h00, 1);

    cur_req = "R8 mode change releases capture lock";
    mode_sel = 2'b00;
    tick(16'h0000);
    tick(16'h0001, 0, 1, 0, 1);
    mode_sel = 2'b01;
    tick(16'h0002);
    mode_sel = 2'b00;
    tick(16'h0003);
    tick(16'h9ABC, 1);
    tick(16'h9ABD, 0, 1, 0, 1);
    tick(16'h9ABE, 0, 1, 0, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule